// File: doc/BRIEF.md
# Display Plane Sequencer Register

This block holds the plane-control setting of a multi-plane LED matrix controller and drives the two-bit index of the plane currently shown. One 8-bit setting covers two uses. It can pin the display to a fixed plane. It can also make the display step through its planes on its own, at a slow rate counted in seconds or a fast rate counted in planes per second.

A new setting is presented on `wrData` and takes effect only in the cycle where `commit` pulses. That pulse marks the end of a complete serial write. `secTick` supplies one pulse per second. `refTick` is a finer time reference that delivers `REF_TICKS` pulses per second, and an internal divider turns it into the fast stepping rate. `twoPlane` selects the pixel-depth mode. When it is 0 there are four planes at one bit per pixel. When it is 1 there are two planes at two bits per pixel.

Top module: `planeSeqReg`

## Requirements
- R1: During and right after reset, `curPlane` is 0 and the stored setting is manual plane 0.
- R2: A commit with bit 6 = 0 (manual) and `twoPlane` = 0 sets `curPlane` to `wrData[1:0]` at the commit edge.
- R3: A manual commit with `twoPlane` = 1 sets `curPlane` to `wrData[0]`. Codes 10 and 11 give planes 0 and 1, and codes 00 and 01 give the same planes.
- R4: A change on `wrData` without `commit` has no effect on `curPlane`.
- R5: A commit with bit 6 = 1 (auto) sets `curPlane` to 0 at the commit edge, even when the block is already in auto mode.
- R6: In auto mode with bit 7 = 0, `curPlane` advances once on every N-th `secTick` after the commit, where N = `wrData[5:0]`.
- R7: In auto mode with bit 7 = 1, `curPlane` advances on refTick number t (counted from the commit) exactly when floor(t·N/REF_TICKS) grows. This gives N evenly spaced steps per REF_TICKS reference ticks.
- R8: With `twoPlane` = 0, an advance from plane 3 returns to plane 0.
- R9: With `twoPlane` = 1, an advance from plane 1 (or higher) returns to plane 0.
- R10: In auto mode with N = 0, `curPlane` holds.
- R11: In manual mode, `secTick` and `refTick` have no effect on `curPlane`.
- R12: Every commit restarts the second counter and the fast divider from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| commit | input | 1 | One-cycle strobe that applies `wrData` |
| wrData | input | 8 | Setting: bit 7 rate unit, bit 6 auto, bits 5:0 rate or plane code |
| secTick | input | 1 | One pulse per second |
| refTick | input | 1 | Fast time reference, REF_TICKS pulses per second |
| twoPlane | input | 1 | 1 = two planes, 0 = four planes |
| curPlane | output | 2 | Index of the plane being displayed |

## Verification
The assertions assume that `commit`, `secTick` and `refTick` are single-cycle pulses. They also assume that REF_TICKS is at least twice the largest rate value, so that two fast steps can never fall on adjacent reference ticks. The bench drives every strobe for exactly one cycle and runs with the default REF_TICKS of 256. It toggles `twoPlane` only rarely, including mid-sequence. Its random settings mix small rates with the full 0 to 63 range so that wraps in both plane modes occur often.

// File: rtl/planeSeqPkg.sv
package planeSeqPkg;
  localparam int CFG_W      = 8;
  localparam int RATE_W     = 6;
  localparam int NUM_PLANES = 4;
  localparam int PLANE_W    = $clog2(NUM_PLANES);

  typedef struct packed {
    logic              fastUnit;
    logic              autoMode;
    logic [RATE_W-1:0] field;
  } seqCfg_t;

  typedef struct packed {
    logic cfgLoad;
    logic autoStart;
    logic advance;
  } seqStrobe_t;
endpackage

// File: rtl/planeRateGen.sv
module planeRateGen #(
  parameter int REF_TICKS = 256,
  parameter int RATE_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              autoMode,
  input  logic              fastUnit,
  input  logic [RATE_W-1:0] rate,
  input  logic              secTick,
  input  logic              refTick,
  output logic              stepPulse
);
  localparam int ACC_W = $clog2(REF_TICKS + (1 << RATE_W));

  logic [ACC_W-1:0]  acc, accSum;
  logic [RATE_W-1:0] secCnt;
  logic rateLive, slowHit, fastHit, slowEn, fastEn;

  always_comb begin
    rateLive = autoMode && (rate != '0);
    slowEn   = rateLive && !fastUnit && secTick;
    fastEn   = rateLive && fastUnit && refTick;
    accSum   = acc + ACC_W'(rate);
    slowHit  = slowEn && (secCnt == rate - 1'b1);
    fastHit  = fastEn && (accSum >= ACC_W'(REF_TICKS));
    stepPulse = !clear && (slowHit || fastHit);
  end

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      secCnt <= '0;
      acc    <= '0;
    end else begin
      if (slowEn) secCnt <= slowHit ? '0 : secCnt + 1'b1;
      if (fastEn) acc <= fastHit ? accSum - ACC_W'(REF_TICKS) : accSum;
    end
  end

  // R7: consecutive fast steps are never on adjacent cycles
  p_fast_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fastHit && !clear) |=> !fastHit);

  // R6: second counter stays below the programmed rate
  p_slow_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rateLive && !fastUnit) |-> (secCnt < rate));
endmodule

// File: rtl/planeSeqCtrl.sv
module planeSeqCtrl
  import planeSeqPkg::*;
#(
  parameter int REF_TICKS = 256
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               commit,
  input  logic [CFG_W-1:0]   wrData,
  input  logic               secTick,
  input  logic               refTick,
  input  logic               twoPlane,
  output seqStrobe_t         strobe,
  output logic [PLANE_W-1:0] manualSel
);
  seqCfg_t cfg, newCfg;
  logic    stepPulse;

  always_comb begin
    newCfg           = seqCfg_t'(wrData);
    strobe.cfgLoad   = commit && !newCfg.autoMode;
    strobe.autoStart = commit && newCfg.autoMode;
    strobe.advance   = stepPulse;
    manualSel        = twoPlane ? {{(PLANE_W-1){1'b0}}, newCfg.field[0]}
                                : newCfg.field[PLANE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)       cfg <= '0;
    else if (commit) cfg <= newCfg;
  end

  planeRateGen #(.REF_TICKS(REF_TICKS), .RATE_W(RATE_W)) i_rateGen (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (commit),
    .autoMode (cfg.autoMode),
    .fastUnit (cfg.fastUnit),
    .rate     (cfg.field),
    .secTick  (secTick),
    .refTick  (refTick),
    .stepPulse(stepPulse)
  );

  // R11: no stepping while in manual mode
  p_manual_still_r11: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.autoMode |-> !strobe.advance);

  // R10: zero rate never steps
  p_zero_rate_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.field == '0) |-> !strobe.advance);
endmodule

// File: rtl/planeSeqDp.sv
module planeSeqDp
  import planeSeqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [PLANE_W-1:0] manualSel,
  input  logic               twoPlane,
  output logic [PLANE_W-1:0] plane
);
  logic [PLANE_W-1:0] lastPlane;

  always_comb lastPlane = twoPlane ? PLANE_W'(1) : PLANE_W'(NUM_PLANES - 1);

  always_ff @(posedge clk) begin
    if (!rstN)                 plane <= '0;
    else if (strobe.autoStart) plane <= '0;
    else if (strobe.cfgLoad)   plane <= manualSel;
    else if (strobe.advance)   plane <= (plane >= lastPlane) ? '0 : plane + 1'b1;
  end

  // R8: four-plane wrap
  p_wrap_four_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.cfgLoad && !strobe.autoStart && !twoPlane
     && plane == PLANE_W'(NUM_PLANES - 1)) |=> (plane == '0));

  // R9: two-plane wrap
  p_wrap_two_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.cfgLoad && !strobe.autoStart && twoPlane
     && plane >= PLANE_W'(1)) |=> (plane == '0));
endmodule

// File: rtl/planeSeqReg.sv
module planeSeqReg #(
  parameter int REF_TICKS = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       commit,
  input  logic [7:0] wrData,
  input  logic       secTick,
  input  logic       refTick,
  input  logic       twoPlane,
  output logic [1:0] curPlane
);
  import planeSeqPkg::*;

  seqStrobe_t         strobe;
  logic [PLANE_W-1:0] manualSel;

  planeSeqCtrl #(.REF_TICKS(REF_TICKS)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .commit   (commit),
    .wrData   (wrData),
    .secTick  (secTick),
    .refTick  (refTick),
    .twoPlane (twoPlane),
    .strobe   (strobe),
    .manualSel(manualSel)
  );

  planeSeqDp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .manualSel(manualSel),
    .twoPlane (twoPlane),
    .plane    (curPlane)
  );

  // R5: entering auto mode starts at plane 0
  p_auto_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    (commit && wrData[6]) |=> (curPlane == 2'd0));

  // R2: four-plane manual selection
  p_manual_pick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (commit && !wrData[6] && !twoPlane) |=> (curPlane == $past(wrData[1:0])));
endmodule

// File: tb/test_planeSeqReg.sv
`timescale 1ns/1ps
module test_planeSeqReg;
  localparam int REF = 256;

  logic clk = 1'b0, rstN = 1'b0, commit = 1'b0;
  logic secTick = 1'b0, refTick = 1'b0, twoPlane = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [1:0] curPlane;

  always #2 clk = ~clk;

  planeSeqReg #(.REF_TICKS(REF)) i_planeSeqReg (
    .clk(clk), .rstN(rstN), .commit(commit), .wrData(wrData),
    .secTick(secTick), .refTick(refTick), .twoPlane(twoPlane),
    .curPlane(curPlane)
  );

  int vecs = 0, errs = 0;
  int mPlane = 0, tS = 0, tF = 0;
  logic [7:0] mReg = 8'h00;
  string tag, forceTag = "";
  bit done = 0;

  function automatic int nextPlane(int p, bit two);
    int last = two ? 1 : 3;
    return (p >= last) ? 0 : p + 1;
  endfunction

  task automatic check(string t, int exp);
    vecs++;
    if (int'(curPlane) != exp) begin
      errs++;
      $display("FAIL %s: curPlane=%0d expected %0d", t, curPlane, exp);
    end
  endtask

  task automatic stepCycle(bit c, logic [7:0] d, bit s, bit r);
    int n;
    bit adv;
    @(negedge clk);
    commit = c; wrData = d; secTick = s; refTick = r;
    adv = 0;
    n = int'(mReg[5:0]);
    if (c) begin
      mReg = d; tS = 0; tF = 0;
      if (d[6]) begin mPlane = 0; tag = "R5"; end
      else begin
        mPlane = twoPlane ? int'(d[0]) : int'(d[1:0]);
        tag = twoPlane ? "R3" : "R2";
      end
    end else if (mReg[6] && n != 0) begin
      tag = mReg[7] ? "R7" : "R6";
      if (!mReg[7] && s) begin
        tS++;
        if (tS % n == 0) adv = 1;
      end
      if (mReg[7] && r) begin
        tF++;
        if ((tF * n) / REF != ((tF - 1) * n) / REF) adv = 1;
      end
      if (adv) begin
        if (mPlane >= (twoPlane ? 1 : 3)) tag = twoPlane ? "R9" : "R8";
        mPlane = nextPlane(mPlane, twoPlane);
      end
    end else begin
      tag = mReg[6] ? "R10" : "R11";
    end
    if (forceTag != "") tag = forceTag;
    @(posedge clk);
    #1;
    check(tag, mPlane);
    commit = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", 0);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1 check("R1", 0);

    // R4: data without commit
    forceTag = "R4";
    stepCycle(0, 8'h03, 0, 0);
    stepCycle(0, 8'h42, 1, 1);
    forceTag = "";
    // R2: manual four-plane
    stepCycle(1, 8'h02, 0, 0);
    stepCycle(1, 8'h03, 0, 0);
    stepCycle(1, 8'h01, 0, 0);
    // R3: manual two-plane, all codes
    twoPlane = 1'b1;
    stepCycle(1, 8'h02, 0, 0);
    stepCycle(1, 8'h03, 0, 0);
    stepCycle(1, 8'h00, 0, 0);
    stepCycle(1, 8'h01, 0, 0);
    // R11: ticks ignored in manual
    for (int i = 0; i < 8; i++) stepCycle(0, 8'h00, 1, 1);
    // R5 + R10: auto with rate 0
    twoPlane = 1'b0;
    stepCycle(1, 8'h03, 0, 0);
    stepCycle(1, 8'h40, 0, 0);
    for (int i = 0; i < 10; i++) stepCycle(0, 8'h00, 1, 1);
    // R6 + R8: slow rate 2, wraps through four planes
    stepCycle(1, 8'h42, 0, 0);
    for (int i = 0; i < 24; i++) stepCycle(0, 8'h00, i % 2 == 0, 1);
    // R5: re-entering auto restarts at 0
    stepCycle(1, 8'h42, 0, 0);
    // R12: commit restarts the second counter
    stepCycle(1, 8'h44, 0, 0);
    for (int i = 0; i < 3; i++) stepCycle(0, 8'h00, 1, 0);
    forceTag = "R12";
    stepCycle(1, 8'h44, 0, 0);
    for (int i = 0; i < 3; i++) stepCycle(0, 8'h00, 1, 0);
    stepCycle(0, 8'h00, 1, 0);
    forceTag = "";
    // R7 + R9: fast rate 63 in two-plane mode
    twoPlane = 1'b1;
    stepCycle(1, 8'hFF, 0, 0);
    for (int i = 0; i < 300; i++) stepCycle(0, 8'h00, 0, 1);
    // R7: fast rate 3, sparse reference ticks
    stepCycle(1, 8'hC3, 0, 0);
    for (int i = 0; i < 600; i++) stepCycle(0, 8'h00, 0, i % 2 == 0);

    // Constrained random
    void'($urandom(32'd20250611));
    for (int i = 0; i < 20000; i++) begin
      bit c;
      logic [7:0] d;
      if ($urandom % 1500 == 0) twoPlane = ~twoPlane;
      c = ($urandom % 400 == 0);
      d = 8'($urandom);
      if (c && ($urandom % 2 == 0)) d[5:0] = 6'($urandom % 8);
      stepCycle(c, d, ($urandom % 4 == 0), ($urandom % 2 == 0));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule